// File: doc/BRIEF.md
# FFT Stage Pair Address Sequencer

This block produces the operand-pair addresses for an in-place radix-2 FFT that has one pipelined butterfly and `N_PTS = 2^STAGES` datapoints. When an idle block sees a start pulse, it runs through stages 0 to `STAGES-1` in order. Each stage takes `N_PTS/2` pair transfers. Every transfer carries two operand indices, the stage number and flags that mark the first and last pair of the stage. Transfers use a valid/ready handshake toward the address remapper that follows this block.

The pairs inside a stage come in rotated-index order, not in plain nested-loop order. Every aligned group of four consecutive operands therefore differs only in two toggling bits, which lets a later bank mapper place each group in four distinct single-ported banks. The read and the write-back of the butterfly overlap in the same cycle. For that reason the block also issues each accepted pair a second time, one cycle later, as the write-back address. A single-cycle done pulse marks the end of the transform.

Top module: `fft_pair_seq`

## Requirements
- R1: While reset is held and after it is released, `rd_valid_o`, `wb_valid_o` and `done_o` are low, and they stay low until a start is taken.
- R2: A start pulse seen while idle makes `rd_valid_o` high in the following cycle, with stage 0, pair 0 and `rd_first_o` high.
- R3: Schedule element i of stage s is the `STAGES`-bit index i rotated left by s, so bit j of the element equals bit (j-s) mod `STAGES` of i. Pair k of a stage presents element 2k on `rd_op1_o` and element 2k+1 on `rd_op2_o`.
- R4: In stage s, `rd_op2_o - rd_op1_o` equals 2^s on every valid cycle.
- R5: Every stage takes exactly `N_PTS/2` accepted pairs. The stages run 0, 1, ..., `STAGES-1`, and `rd_stage_o` rises by one right after the last pair of a stage is accepted.
- R6: `rd_first_o` is high only on pair 0 of a stage, and `rd_last_o` is high only on pair `N_PTS/2-1`.
- R7: While `rd_valid_o` is high and `rd_ready_i` is low, the next cycle shows the same pair, stage and flags, and valid stays high.
- R8: `wb_valid_o` is high for exactly the one cycle after each accepted transfer. In that cycle `wb_op1_o` and `wb_op2_o` show the pair that was accepted. Between accepts they keep their value.
- R9: `done_o` is high for exactly one cycle, the cycle after the last pair of stage `STAGES-1` is accepted. In that cycle `rd_valid_o` is low.
- R10: A start pulse during a transform is ignored, and the schedule carries on without a restart.
- R11: For every stage s, the four operands of pairs 2m and 2m+1, taken in order, agree in all bits except bit (s+1) mod `STAGES` and bit s. Those two bits, read as {bit (s+1) mod `STAGES`, bit s}, count 0, 1, 2, 3. In the last stage this makes bits 0 and `STAGES-1` the toggling bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a transform when idle |
| rd_ready_i | input | 1 | Downstream accepts the current pair |
| rd_valid_o | output | 1 | Pair outputs are valid |
| rd_op1_o | output | STAGES | First operand index |
| rd_op2_o | output | STAGES | Second operand index |
| rd_stage_o | output | SW | Stage number |
| rd_first_o | output | 1 | First pair of the stage |
| rd_last_o | output | 1 | Last pair of the stage |
| wb_valid_o | output | 1 | Write-back address strobe |
| wb_op1_o | output | STAGES | Write-back first operand |
| wb_op2_o | output | STAGES | Write-back second operand |
| done_o | output | 1 | Transform complete pulse |

## Verification
A start taken while idle shows up as a valid pair one cycle later. A new pair appears one cycle after each accept, and the write-back strobe and the done pulse also come one cycle after the accept that causes them. The bench drives inputs and samples outputs on the falling edge. At each falling edge it first compares the outputs with a model state that it updated at the previous falling edge from the accept it had decided on then. That way every expected value refers to exactly one rising edge. Ready is random with long stalls mixed in, start pulses arrive both while the block is idle and while it is busy, and the groups of four operands are checked against the toggling-bit rule.

// File: rtl/fft_pair_seq_pkg.sv
package fft_pair_seq_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/fft_pair_cnt.sv
module fft_pair_cnt
  import fft_pair_seq_pkg::*;
#(
  parameter int unsigned STAGES = 4,
  parameter int unsigned SW     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic              accept_o,
  output logic [SW-1:0]     stage_o,
  output logic [STAGES-2:0] pair_o,
  output logic              first_o,
  output logic              last_o,
  output logic              done_o
);
  localparam int unsigned PW = STAGES - 1;
  localparam logic [PW-1:0] PAIR_LAST  = {PW{1'b1}};
  localparam logic [SW-1:0] STAGE_LAST = SW'(STAGES - 1);

  seq_state_e    state_q;
  logic [SW-1:0] stage_q;
  logic [PW-1:0] pair_q;
  logic          done_q;
  logic          busy, accept, pair_end, stage_end;

  assign busy      = (state_q == SEQ_RUN);
  assign accept    = busy && ready_i;
  assign pair_end  = (pair_q == PAIR_LAST);
  assign stage_end = (stage_q == STAGE_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      stage_q <= '0;
      pair_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= accept && pair_end && stage_end;
      if (!busy) begin
        if (start_i) begin
          state_q <= SEQ_RUN;
          stage_q <= '0;
          pair_q  <= '0;
        end
      end else if (accept) begin
        if (pair_end) begin
          pair_q <= '0;
          if (stage_end) state_q <= SEQ_IDLE;
          else           stage_q <= stage_q + SW'(1);
        end else begin
          pair_q <= pair_q + PW'(1);
        end
      end
    end
  end

  assign valid_o  = busy;
  assign accept_o = accept;
  assign stage_o  = stage_q;
  assign pair_o   = pair_q;
  assign first_o  = busy && (pair_q == '0);
  assign last_o   = busy && pair_end;
  assign done_o   = done_q;

  a_r2_start_kick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o && start_i |=> valid_o && first_o && stage_o == '0);

  a_r5_stage_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o && last_o && !stage_end |=> valid_o && first_o && stage_o == $past(stage_o) + SW'(1));

  a_r10_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o && start_i && !last_o |=> valid_o && pair_o == $past(pair_o) + PW'(1)
                                        && stage_o == $past(stage_o));
endmodule

// File: rtl/fft_pair_rot.sv
module fft_pair_rot #(
  parameter int unsigned STAGES = 4,
  parameter int unsigned SW     = 2
) (
  input  logic [SW-1:0]     stage_i,
  input  logic [STAGES-2:0] pair_i,
  output logic [STAGES-1:0] op1_o,
  output logic [STAGES-1:0] op2_o
);
  logic [STAGES-1:0] even_idx, odd_idx;
  logic [STAGES-1:0] rot_even [STAGES];
  logic [STAGES-1:0] rot_odd  [STAGES];

  assign even_idx = {pair_i, 1'b0};
  assign odd_idx  = {pair_i, 1'b1};

  // one left-rotated copy per stage, picked by the stage count
  for (genvar s = 0; s < STAGES; s++) begin : g_rot
    if (s == 0) begin : g_id
      assign rot_even[s] = even_idx;
      assign rot_odd[s]  = odd_idx;
    end else begin : g_rl
      assign rot_even[s] = {even_idx[STAGES-1-s:0], even_idx[STAGES-1:STAGES-s]};
      assign rot_odd[s]  = {odd_idx[STAGES-1-s:0],  odd_idx[STAGES-1:STAGES-s]};
    end
  end

  assign op1_o = rot_even[stage_i];
  assign op2_o = rot_odd[stage_i];
endmodule

// File: rtl/fft_pair_wb.sv
module fft_pair_wb #(
  parameter int unsigned STAGES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [STAGES-1:0] op1_i,
  input  logic [STAGES-1:0] op2_i,
  output logic              wb_valid_o,
  output logic [STAGES-1:0] wb_op1_o,
  output logic [STAGES-1:0] wb_op2_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_valid_o <= 1'b0;
      wb_op1_o   <= '0;
      wb_op2_o   <= '0;
    end else begin
      wb_valid_o <= accept_i;
      if (accept_i) begin
        wb_op1_o <= op1_i;
        wb_op2_o <= op2_i;
      end
    end
  end

  a_r8_wb_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> wb_valid_o && wb_op1_o == $past(op1_i) && wb_op2_o == $past(op2_i));

  a_r8_wb_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> !wb_valid_o && $stable(wb_op1_o) && $stable(wb_op2_o));
endmodule

// File: rtl/fft_pair_seq.sv
module fft_pair_seq #(
  parameter int unsigned N_PTS = 16,
  localparam int unsigned STAGES = $clog2(N_PTS),
  localparam int unsigned SW = (STAGES > 1) ? $clog2(STAGES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_ready_i,
  output logic              rd_valid_o,
  output logic [STAGES-1:0] rd_op1_o,
  output logic [STAGES-1:0] rd_op2_o,
  output logic [SW-1:0]     rd_stage_o,
  output logic              rd_first_o,
  output logic              rd_last_o,
  output logic              wb_valid_o,
  output logic [STAGES-1:0] wb_op1_o,
  output logic [STAGES-1:0] wb_op2_o,
  output logic              done_o
);
  logic              accept;
  logic [STAGES-2:0] pair;

  fft_pair_cnt #(.STAGES(STAGES), .SW(SW)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .ready_i  (rd_ready_i),
    .valid_o  (rd_valid_o),
    .accept_o (accept),
    .stage_o  (rd_stage_o),
    .pair_o   (pair),
    .first_o  (rd_first_o),
    .last_o   (rd_last_o),
    .done_o   (done_o)
  );

  fft_pair_rot #(.STAGES(STAGES), .SW(SW)) u_rot (
    .stage_i (rd_stage_o),
    .pair_i  (pair),
    .op1_o   (rd_op1_o),
    .op2_o   (rd_op2_o)
  );

  fft_pair_wb #(.STAGES(STAGES)) u_wb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .op1_i      (rd_op1_o),
    .op2_i      (rd_op2_o),
    .wb_valid_o (wb_valid_o),
    .wb_op1_o   (wb_op1_o),
    .wb_op2_o   (wb_op2_o)
  );

  a_r4_pair_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (rd_op2_o - rd_op1_o) == (STAGES'(1) << rd_stage_o));

  a_r7_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_op1_o) && $stable(rd_op2_o)
                                  && $stable(rd_stage_o) && $stable(rd_first_o) && $stable(rd_last_o));

  a_r9_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !rd_valid_o);

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/fft_pair_seq_bench.sv
`timescale 1ns/1ps
module fft_pair_seq_bench;
  localparam int D  = 16;
  localparam int S  = 4;
  localparam int SW = 2;
  localparam int NP = D / 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic          rd_ready_i = 1'b0;
  logic          rd_valid_o, rd_first_o, rd_last_o, wb_valid_o, done_o;
  logic [S-1:0]  rd_op1_o, rd_op2_o, wb_op1_o, wb_op2_o;
  logic [SW-1:0] rd_stage_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  fft_pair_seq #(.N_PTS(D)) u_fft_pair_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .rd_ready_i(rd_ready_i),
    .rd_valid_o(rd_valid_o), .rd_op1_o(rd_op1_o), .rd_op2_o(rd_op2_o),
    .rd_stage_o(rd_stage_o), .rd_first_o(rd_first_o), .rd_last_o(rd_last_o),
    .wb_valid_o(wb_valid_o), .wb_op1_o(wb_op1_o), .wb_op2_o(wb_op2_o), .done_o(done_o)
  );

  function automatic logic [S-1:0] ref_elem(int i, int s);
    logic [31:0]  ii = i;
    logic [S-1:0] r;
    for (int j = 0; j < S; j++) r[j] = ii[(j - s + S) % S];
    return r;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    summary();
  end

  initial begin
    bit exp_busy = 0, exp_done = 0, exp_wbv = 0, stalled = 0, ign = 0;
    int s = 0, p = 0, n_xfm = 0;
    logic [S-1:0] wb1 = '0, wb2 = '0, g0 = '0, g1 = '0;
    void'($urandom(32'd4242));

    repeat (3) @(negedge clk_i);
    chk("R1 reset valid", rd_valid_o, 0);
    chk("R1 reset wb_valid", wb_valid_o, 0);
    chk("R1 reset done", done_o, 0);
    rst_ni = 1'b1;

    for (int cyc = 0; cyc < 3000; cyc++) begin
      bit rdy, st, acc;
      @(negedge clk_i);
      chk(exp_busy ? "R2 valid" : "R1 valid idle", rd_valid_o, exp_busy);
      if (exp_busy) begin
        chk(stalled ? "R7 op1 held" : (ign ? "R10 op1 no restart" : "R3 op1"),
            rd_op1_o, ref_elem(2*p, s));
        chk(stalled ? "R7 op2 held" : "R3 op2", rd_op2_o, ref_elem(2*p+1, s));
        chk("R4 gap", int'(rd_op2_o) - int'(rd_op1_o), 1 << s);
        chk(ign ? "R10 stage" : "R5 stage", rd_stage_o, s);
        chk("R6 first", rd_first_o, p == 0);
        chk("R6 last", rd_last_o, p == NP-1);
      end
      chk("R8 wb_valid", wb_valid_o, exp_wbv);
      chk("R8 wb_op1", wb_op1_o, wb1);
      chk("R8 wb_op2", wb_op2_o, wb2);
      chk("R9 done", done_o, exp_done);

      if (cyc < 200) rdy = !(cyc >= 40 && cyc < 44);
      else if (cyc >= 600 && cyc < 640) rdy = 1'b0;
      else rdy = ($urandom % 100) < 65;
      if (cyc == 5 || cyc == 20 || cyc == 150) st = 1'b1;
      else if (cyc >= 200) st = ($urandom % 100) < 10;
      else st = 1'b0;
      rd_ready_i = rdy;
      start_i    = st;

      acc      = exp_busy && rdy;
      stalled  = exp_busy && !rdy;
      ign      = exp_busy && st;
      exp_wbv  = acc;
      exp_done = 1'b0;
      if (acc) begin
        logic [S-1:0] e1, e2;
        e1 = ref_elem(2*p, s);
        e2 = ref_elem(2*p+1, s);
        wb1 = e1;
        wb2 = e2;
        if (p % 2 == 1) begin
          logic [S-1:0] grp [4];
          int hi;
          logic [S-1:0] mask;
          grp[0] = g0; grp[1] = g1; grp[2] = e1; grp[3] = e2;
          hi   = (s + 1) % S;
          mask = ~((S'(1) << hi) | (S'(1) << s));
          for (int q = 0; q < 4; q++) begin
            chk("R11 toggle count", {grp[q][hi], grp[q][s]}, q);
            chk("R11 fixed bits", grp[q] & mask, grp[0] & mask);
          end
        end else begin
          g0 = e1;
          g1 = e2;
        end
        if (p == NP-1) begin
          p = 0;
          if (s == S-1) begin
            exp_busy = 1'b0;
            exp_done = 1'b1;
            n_xfm++;
          end else s++;
        end else p++;
      end else if (!exp_busy && st) begin
        exp_busy = 1'b1;
        s = 0;
        p = 0;
      end
    end
    chk("R9 transforms completed", n_xfm >= 4, 1);
    summary();
  end
endmodule